// File: doc/BRIEF.md
# Serial Configuration Loader

This block programs a target device whose configuration port is a one-bit serial input clocked by the host. On a start pulse it holds the active-low program-reset line low for a fixed number of cycles, releases it, and waits for the target to raise its init line. It then takes image bytes from a valid/ready stream and shifts each one out on a data line against a configuration clock that it generates itself. The target has no flow-control line, so bits are clocked at a fixed pace with no waiting.

During transfer the block watches the target's init and done lines. A falling init line stops the load with an error. If done rises before the image ends, the rest of the image is left in the stream and the block moves to completion. Once the image is sent, the block clocks filler bytes of all ones until done rises. It then reports success if init and done are both high. Timeouts limit each wait, and an abort input ends a load at once.

Top module: `serial_cfg_loader`

## Requirements
- R1: After reset and while idle, the program line and the configuration clock are high. `busy_o`, `ready_o`, `success_o` and `error_o` are low.
- R2: A start pulse in idle drives the program line low for exactly PROG_LOW_CYC cycles, then releases it. No configuration clock edge reaches the target before the init line is high.
- R3: If init stays low for INIT_WAIT_CYC cycles after the program line is released, the load ends with `error_o` high and `err_code_o` = 2 (timeout).
- R4: Each byte is sent most-significant bit first. The data line changes only while the configuration clock is low, and the target samples on the rising clock edge. Each clock phase lasts HALF_CYC cycles (HALF_CYC of at least 2).
- R5: `ready_o` is high only when the shifter needs a byte during the load and init is high and done is low. One byte is taken per handshake, and the byte flagged by `last_i` ends the image.
- R6: If init falls during the load or the filler phase, the load ends with `error_o` high and `err_code_o` = 1.
- R7: If done is high at a byte boundary during the load, no further input byte is accepted and the block goes to completion.
- R8: After the image, filler bytes of 0xFF are clocked until done is high at a byte boundary. `success_o` is then raised, only with init and done both high and with `err_code_o` = 0.
- R9: If done does not rise within DONE_WAIT_CYC cycles of the filler phase, the load ends with `err_code_o` = 2.
- R10: `abort_i` during a load drives the program line low on the next cycle, returns to idle and reports `err_code_o` = 3.
- R11: `success_o` and `error_o` are never high together. Both hold until the next start, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a load (pulse, taken in idle) |
| abort_i | input | 1 | End the current load at once |
| data_i | input | 8 | Image byte |
| valid_i | input | 1 | Image byte valid |
| last_i | input | 1 | Marks the final image byte |
| ready_o | output | 1 | Block takes the byte this cycle |
| cfg_prog_no | output | 1 | Program-reset line to the target, active low |
| cfg_clk_o | output | 1 | Configuration clock to the target |
| cfg_dat_o | output | 1 | Serial configuration data |
| cfg_init_i | input | 1 | Target init line (high = ready / no error) |
| cfg_done_i | input | 1 | Target done line |
| busy_o | output | 1 | Load in progress |
| success_o | output | 1 | Last load completed successfully |
| error_o | output | 1 | Last load failed |
| err_code_o | output | 2 | 0 none, 1 init lost, 2 timeout, 3 aborted |

## Verification
The checker watches these properties on every cycle:
- The data line moves only while the configuration clock is low.
- The minimum clock phase width holds, and the clock stays high while the program line is low.
- Ready appears only with init high and done low.
- Success rises only after init and done were both high.
- Abort causes its one-cycle program pulse.
- Success and error are exclusive.

Only the bench's scenarios can show the rest:
- The bit order and the byte contents seen at the target.
- The exact program pulse width.
- How many stream bytes are consumed on an early done.
- The count of filler bits sent.
- Which error code each init loss or timeout produces.

// File: rtl/cfg_ldr_pkg.sv
package cfg_ldr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PROG, ST_WINIT, ST_LOAD, ST_FLUSH
  } ldr_state_e;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_INIT    = 2'd1,
    ERR_TIMEOUT = 2'd2,
    ERR_ABORT   = 2'd3
  } ldr_err_e;

  localparam int unsigned BYTE_W    = 8;
  localparam logic [7:0]  FILL_BYTE = 8'hFF;
endpackage

// File: rtl/cfg_ldr_timer.sv
module cfg_ldr_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  assign expired_o = en_i && (cnt_q >= limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (clr_i)                cnt_q <= '0;
    else if (en_i && !expired_o)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cfg_ldr_serializer.sv
module cfg_ldr_serializer #(
  parameter int unsigned HALF_CYC = 2,
  parameter int unsigned DATA_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] byte_i,
  output logic              active_o,
  output logic              sclk_o,
  output logic              sdat_o
);
  localparam int unsigned DIV_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam int unsigned BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_CYC - 1);

  logic              active_q, phase_q;
  logic [DIV_W-1:0]  div_q;
  logic [BIT_W-1:0]  bit_q;
  logic [DATA_W-1:0] sh_q;

  // phase_q: 0 = clock low half, 1 = clock high half
  assign active_o = active_q;
  assign sclk_o   = !active_q || phase_q;
  assign sdat_o   = sh_q[DATA_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      phase_q  <= 1'b0;
      div_q    <= '0;
      bit_q    <= '0;
      sh_q     <= '1;
    end else if (flush_i) begin
      active_q <= 1'b0;
    end else if (!active_q) begin
      if (load_i) begin
        active_q <= 1'b1;
        sh_q     <= byte_i;
        bit_q    <= BIT_W'(DATA_W - 1);
        phase_q  <= 1'b0;
        div_q    <= '0;
      end
    end else if (div_q == DIV_LAST) begin
      div_q <= '0;
      if (!phase_q) begin
        phase_q <= 1'b1;
      end else begin
        phase_q <= 1'b0;
        if (bit_q == '0) begin
          active_q <= 1'b0;
        end else begin
          // shift only between bits so data moves with the falling clock
          bit_q <= bit_q - 1'b1;
          sh_q  <= {sh_q[DATA_W-2:0], 1'b1};
        end
      end
    end else begin
      div_q <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
  import cfg_ldr_pkg::*;
#(
  parameter int unsigned HALF_CYC      = 2,
  parameter int unsigned PROG_LOW_CYC  = 16,
  parameter int unsigned INIT_WAIT_CYC = 1000,
  parameter int unsigned DONE_WAIT_CYC = 100000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       abort_i,
  input  logic [7:0] data_i,
  input  logic       valid_i,
  input  logic       last_i,
  output logic       ready_o,
  output logic       cfg_prog_no,
  output logic       cfg_clk_o,
  output logic       cfg_dat_o,
  input  logic       cfg_init_i,
  input  logic       cfg_done_i,
  output logic       busy_o,
  output logic       success_o,
  output logic       error_o,
  output logic [1:0] err_code_o
);
  localparam int unsigned MAX_AB   = (PROG_LOW_CYC > INIT_WAIT_CYC) ? PROG_LOW_CYC : INIT_WAIT_CYC;
  localparam int unsigned MAX_WAIT = (MAX_AB > DONE_WAIT_CYC) ? MAX_AB : DONE_WAIT_CYC;
  localparam int unsigned TMR_W    = $clog2(MAX_WAIT + 1);

  ldr_state_e st_q, st_d;
  ldr_err_e   err_d, err_q;
  logic       fin_ok, fin_err, abort_hit;
  logic       ser_load, ser_flush, ser_active;
  logic [7:0] ser_byte;
  logic       tmr_en, tmr_exp;
  logic [TMR_W-1:0] tmr_limit;
  logic       hs;
  logic       prog_q, succ_q, errf_q;

  assign ready_o = (st_q == ST_LOAD) && !ser_active && cfg_init_i && !cfg_done_i;
  assign hs      = ready_o && valid_i;

  always_comb begin
    tmr_en    = 1'b1;
    tmr_limit = '0;
    unique case (st_q)
      ST_PROG:  tmr_limit = TMR_W'(PROG_LOW_CYC - 1);
      ST_WINIT: tmr_limit = TMR_W'(INIT_WAIT_CYC);
      ST_FLUSH: tmr_limit = TMR_W'(DONE_WAIT_CYC);
      default:  tmr_en    = 1'b0;
    endcase
  end

  cfg_ldr_timer #(.CNT_W(TMR_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (st_d != st_q),
    .en_i      (tmr_en),
    .limit_i   (tmr_limit),
    .expired_o (tmr_exp)
  );

  always_comb begin
    st_d      = st_q;
    ser_load  = 1'b0;
    ser_byte  = data_i;
    fin_ok    = 1'b0;
    fin_err   = 1'b0;
    err_d     = ERR_NONE;
    abort_hit = 1'b0;
    unique case (st_q)
      ST_IDLE:  if (start_i) st_d = ST_PROG;
      ST_PROG:  if (tmr_exp) st_d = ST_WINIT;
      ST_WINIT: begin
        if (cfg_init_i) st_d = ST_LOAD;
        else if (tmr_exp) begin fin_err = 1'b1; err_d = ERR_TIMEOUT; end
      end
      ST_LOAD: begin
        if (!cfg_init_i) begin
          fin_err = 1'b1; err_d = ERR_INIT;
        end else if (!ser_active && cfg_done_i) begin
          st_d = ST_FLUSH;  // early done: leave rest of image unsent
        end else if (hs) begin
          ser_load = 1'b1;
          if (last_i) st_d = ST_FLUSH;
        end
      end
      ST_FLUSH: begin
        if (!cfg_init_i) begin
          fin_err = 1'b1; err_d = ERR_INIT;
        end else if (!ser_active && cfg_done_i) begin
          fin_ok = 1'b1;
        end else if (tmr_exp) begin
          fin_err = 1'b1; err_d = ERR_TIMEOUT;
        end else if (!ser_active) begin
          ser_load = 1'b1;
          ser_byte = FILL_BYTE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (abort_i && st_q != ST_IDLE) begin
      abort_hit = 1'b1;
      fin_ok    = 1'b0;
      fin_err   = 1'b1;
      err_d     = ERR_ABORT;
      ser_load  = 1'b0;
    end
    if (fin_ok || fin_err) st_d = ST_IDLE;
  end

  assign ser_flush = fin_ok || fin_err;

  cfg_ldr_serializer #(.HALF_CYC(HALF_CYC), .DATA_W(BYTE_W)) u_ser (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flush_i  (ser_flush),
    .load_i   (ser_load),
    .byte_i   (ser_byte),
    .active_o (ser_active),
    .sclk_o   (cfg_clk_o),
    .sdat_o   (cfg_dat_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      prog_q <= 1'b1;
      succ_q <= 1'b0;
      errf_q <= 1'b0;
      err_q  <= ERR_NONE;
    end else begin
      st_q   <= st_d;
      prog_q <= !((st_d == ST_PROG) || abort_hit);
      if (st_q == ST_IDLE && start_i) begin
        succ_q <= 1'b0;
        errf_q <= 1'b0;
        err_q  <= ERR_NONE;
      end else if (fin_err) begin
        errf_q <= 1'b1;
        err_q  <= err_d;
      end else if (fin_ok) begin
        succ_q <= 1'b1;
      end
    end
  end

  assign cfg_prog_no = prog_q;
  assign busy_o      = (st_q != ST_IDLE);
  assign success_o   = succ_q;
  assign error_o     = errf_q;
  assign err_code_o  = err_q;
endmodule

// File: rtl/cfg_ldr_chk.sv
module cfg_ldr_chk #(
  parameter int unsigned HALF_CYC = 2
) (
  input logic clk_i,
  input logic rst_ni,
  input logic abort_i,
  input logic ready_o,
  input logic cfg_prog_no,
  input logic cfg_clk_o,
  input logic cfg_dat_o,
  input logic cfg_init_i,
  input logic cfg_done_i,
  input logic busy_o,
  input logic success_o,
  input logic error_o
);
  a_r2_clk_idle_in_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_prog_no |-> cfg_clk_o);

  a_r4_data_moves_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg_dat_o) |-> !cfg_clk_o);

  generate
    if (HALF_CYC >= 2) begin : g_width
      a_r4_high_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(cfg_clk_o) |=> cfg_clk_o);
      a_r4_low_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(cfg_clk_o) |=> (!cfg_clk_o || !busy_o));
    end
  endgenerate

  a_r5_ready_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (busy_o && cfg_init_i && !cfg_done_i));

  a_r8_success_lines: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(success_o) |-> ($past(cfg_init_i) && $past(cfg_done_i)));

  a_r10_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_i && busy_o) |=> (!busy_o && !cfg_prog_no && error_o));

  a_r11_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(success_o && error_o));
endmodule

bind serial_cfg_loader cfg_ldr_chk #(.HALF_CYC(HALF_CYC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .abort_i     (abort_i),
  .ready_o     (ready_o),
  .cfg_prog_no (cfg_prog_no),
  .cfg_clk_o   (cfg_clk_o),
  .cfg_dat_o   (cfg_dat_o),
  .cfg_init_i  (cfg_init_i),
  .cfg_done_i  (cfg_done_i),
  .busy_o      (busy_o),
  .success_o   (success_o),
  .error_o     (error_o)
);

// File: tb/serial_cfg_loader_tb_top.sv
`timescale 1ns/1ps
module serial_cfg_loader_tb_top;
  localparam int HALF   = 2;
  localparam int PLOW   = 8;
  localparam int IWAIT  = 60;
  localparam int DWAIT  = 400;
  localparam int NEVER  = 1000000;
  localparam int NVEC   = 7;
  // n_bytes, init_delay, done_at_bit, drop_at_bit, exp_code, exp_consumed, exp_bits(-1 skip)
  localparam int VEC [NVEC][7] = '{
    '{3, 2,     32,    NEVER, 0, 3, 32},
    '{4, 0,     12,    NEVER, 0, 2, 16},
    '{2, 3,     NEVER, 5,     1, 1, -1},
    '{2, 1,     NEVER, NEVER, 2, 2, -1},
    '{2, NEVER, NEVER, NEVER, 2, 0, 0},
    '{1, 0,     8,     NEVER, 0, 1, 8},
    '{1, 0,     NEVER, 12,    1, 1, -1}
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, abort_i = 1'b0;
  logic [7:0] data_i;
  logic valid_i, last_i, ready_o;
  logic cfg_prog_no, cfg_clk_o, cfg_dat_o;
  logic cfg_init_i, cfg_done_i;
  logic busy_o, success_o, error_o;
  logic [1:0] err_code_o;

  int checks = 0, failures = 0;

  // stream feeder state
  int  n_bytes = 0, idx = 0;
  bit  feed_en = 1'b0, pend = 1'b0;
  // target model state
  int  init_delay = 0, done_at = NEVER, drop_at = NEVER;
  int  rel_cnt = 0, bitcnt = 0, pre_init_rises = 0, prog_low_cnt = 0;
  bit  released = 1'b0, init_line = 1'b0, done_line = 1'b0, clk_prev = 1'b1;
  logic [7:0] sr = '0;
  logic [7:0] cap [16];

  always #2.5 clk_i = ~clk_i;

  function automatic logic [7:0] pat(input int k);
    return 8'(8'h3C + k * 8'h59);
  endfunction

  assign valid_i    = feed_en && (idx < n_bytes);
  assign data_i     = pat(idx);
  assign last_i     = (idx == n_bytes - 1);
  assign cfg_init_i = init_line;
  assign cfg_done_i = done_line;

  serial_cfg_loader #(
    .HALF_CYC(HALF), .PROG_LOW_CYC(PLOW), .INIT_WAIT_CYC(IWAIT), .DONE_WAIT_CYC(DWAIT)
  ) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .abort_i(abort_i),
    .data_i(data_i), .valid_i(valid_i), .last_i(last_i), .ready_o(ready_o),
    .cfg_prog_no(cfg_prog_no), .cfg_clk_o(cfg_clk_o), .cfg_dat_o(cfg_dat_o),
    .cfg_init_i(cfg_init_i), .cfg_done_i(cfg_done_i), .busy_o(busy_o),
    .success_o(success_o), .error_o(error_o), .err_code_o(err_code_o)
  );

  // feeder: handshake seen at a negedge, index advances one cycle later
  always @(negedge clk_i) begin
    if (pend) begin
      idx  = idx + 1;
      pend = 1'b0;
    end else if (valid_i && ready_o) begin
      pend = 1'b1;
    end
  end

  // target model
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      clk_prev = 1'b1;
    end else if (!cfg_prog_no) begin
      prog_low_cnt = prog_low_cnt + 1;
      released = 1'b0; rel_cnt = 0; bitcnt = 0;
      init_line = 1'b0; done_line = 1'b0;
    end else begin
      if (!released) begin
        if (rel_cnt >= init_delay) released = 1'b1;
        else rel_cnt = rel_cnt + 1;
      end
      if (cfg_clk_o && !clk_prev) begin
        if (!init_line) pre_init_rises = pre_init_rises + 1;
        else begin
          bitcnt = bitcnt + 1;
          sr = {sr[6:0], cfg_dat_o};
          if (bitcnt % 8 == 0 && bitcnt / 8 <= 16) cap[bitcnt/8 - 1] = sr;
        end
      end
      init_line = released && !(bitcnt >= drop_at);
      done_line = released && (bitcnt >= done_at);
    end
    clk_prev = cfg_clk_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
  endtask

  task automatic wait_idle();
    for (int t = 0; t < 5000 && busy_o; t++) @(negedge clk_i);
    repeat (2) @(negedge clk_i);
  endtask

  task automatic setup(input int nb, input int idl, input int dn, input int dr);
    @(negedge clk_i);
    n_bytes = nb; idx = 0; pend = 1'b0; feed_en = 1'b1;
    init_delay = idl; done_at = dn; drop_at = dr;
    pre_init_rises = 0; prog_low_cnt = 0;
  endtask

  initial begin
    #(150000 * 5);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    // R1 reset state
    chk(cfg_prog_no && cfg_clk_o, "R1 prog/clk high", {cfg_prog_no, cfg_clk_o}, 3);
    chk(!busy_o && !ready_o && !success_o && !error_o, "R1 status low",
        {busy_o, ready_o, success_o, error_o}, 0);

    for (int v = 0; v < NVEC; v++) begin
      setup(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);
      pulse_start();
      chk(!success_o && !error_o, "R11 cleared by start", {success_o, error_o}, 0);
      wait_idle();
      // R2 program pulse width
      chk(prog_low_cnt == PLOW, "R2 prog low width", prog_low_cnt, PLOW);
      if (VEC[v][3] == NEVER)
        chk(pre_init_rises == 0, "R2 no clock before init", pre_init_rises, 0);
      if (VEC[v][4] == 0) begin
        chk(success_o && !error_o && err_code_o == 2'd0, "R8 success", {success_o, error_o}, 2);
      end else begin
        chk(error_o && !success_o, "R6/R3/R9 error flag", {success_o, error_o}, 1);
        // code 1 = init lost (R6), code 2 = timeout (R3 when no init, R9 in filler)
        chk(int'(err_code_o) == VEC[v][4],
            (VEC[v][5] == 0) ? "R3 code" : (VEC[v][4] == 1 ? "R6 code" : "R9 code"),
            err_code_o, VEC[v][4]);
      end
      // R5 / R7 consumed bytes
      chk(idx == VEC[v][5], (v == 1) ? "R7 early done consumed" : "R5 consumed", idx, VEC[v][5]);
      if (VEC[v][6] >= 0)
        chk(bitcnt == VEC[v][6], "R8 filler bit count", bitcnt, VEC[v][6]);
      // R4 MSB first content; filler bytes all ones (R8)
      for (int k = 0; k < bitcnt / 8 && k < 16; k++) begin
        chk(cap[k] == ((k < VEC[v][5]) ? pat(k) : 8'hFF), "R4 byte content",
            cap[k], (k < VEC[v][5]) ? pat(k) : 8'hFF);
      end
      feed_en = 1'b0;
    end

    // R10 abort during load
    setup(5, 0, NEVER, NEVER);
    pulse_start();
    for (int t = 0; t < 2000 && bitcnt < 3; t++) @(negedge clk_i);
    abort_i = 1'b1;
    @(negedge clk_i);
    abort_i = 1'b0;
    chk(!cfg_prog_no, "R10 prog low on abort", cfg_prog_no, 0);
    chk(!busy_o, "R10 idle after abort", busy_o, 0);
    chk(error_o && err_code_o == 2'd3, "R10 abort code", err_code_o, 3);
    repeat (10) @(negedge clk_i);
    chk(error_o && !success_o, "R11 error held", {success_o, error_o}, 1);
    chk(cfg_prog_no && cfg_clk_o, "R1 idle lines after abort", {cfg_prog_no, cfg_clk_o}, 3);
    feed_en = 1'b0;

    // R11 a fresh good load clears the old error
    setup(1, 0, 8, NEVER);
    pulse_start();
    chk(busy_o && !error_o, "R11 error cleared", error_o, 0);
    wait_idle();
    chk(success_o && !error_o, "R8 success after abort", success_o, 1);
    feed_en = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule